// File: doc/BRIEF.md
# Mailbox Read Coherency Lock

This block sits on the host register bus in front of an array of receive mailboxes. It lets the host read a whole received frame as one consistent snapshot. It watches every host access. When the host reads a mailbox's control/status word, that mailbox becomes locked, and the receive engine must hold off writing new frames into it. Only one mailbox is ever locked. The lock is released in one of three ways: the host reads the free-running timer register, the host reads the control/status word of a different mailbox, or the host writes the control/status word of the locked mailbox.

The receive engine reports, per mailbox, whether it is in the middle of updating that mailbox. A control/status read of such a mailbox raises a one-cycle busy indication towards the host. Software can then retry, and that read leaves the lock as it was. Reading the interrupt flag register never touches the lock, so software can poll status freely. Mailbox storage, identifier matching and the serial protocol are outside this block.

Top module: `mbx_rdlock`

## Requirements
- R1: After reset, lock_valid and host_busy are low.
- R2: A host read whose word address has bit 7 set selects a mailbox. Bits 6:3 give the mailbox index and bits 2:0 give the word within it, with word 0 being the control/status word. A read of word 0 of a mailbox whose rx_busy bit is low makes lock_valid high and lock_idx equal to that index, from the clock edge that samples the read.
- R3: Such a control/status read of a different mailbox moves the lock to the new mailbox, so that at most one mailbox is locked.
- R4: A host read of the timer register (word address 0x04) clears lock_valid on the sampling edge.
- R5: Reads of the flag register (word address 0x08), of mailbox words 1 to 7, and of any other register leave lock_valid and lock_idx unchanged.
- R6: A control/status read of a mailbox whose rx_busy bit is high drives host_busy high for the following cycle and leaves the lock unchanged. host_busy is low after any other access and while the bus is idle.
- R7: A host write to word 0 of the locked mailbox clears lock_valid. Writes to other mailboxes, to other words, or to registers leave the lock unchanged.
- R8: When host_rd and host_wr are both high in the same cycle, the access is handled as a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe, one access per high cycle |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host word address |
| rx_busy | input | 16 | Per-mailbox flag: receive engine is updating this mailbox |
| lock_valid | output | 1 | A mailbox is locked |
| lock_idx | output | 4 | Index of the locked mailbox, meaningful while lock_valid is high |
| host_busy | output | 1 | The previous control/status read hit a busy mailbox |

## Verification
The assertions take each cycle with a strobe high as exactly one complete access. They take rx_busy as stable during the access cycle. They also assume the timer and flag addresses lie outside the mailbox region. The stimulus drives inputs only on the falling edge and holds them for a single cycle. It draws addresses mostly from control words, mailbox payload words, and the timer and flag registers, and it gives rx_busy a low probability per bit. It also drives a few cycles with both strobes high, so that the read-priority rule is exercised.

// File: rtl/mbx_rdlock_pkg.sv
package mbx_rdlock_pkg;
  typedef struct packed {
    logic ctrl_rd;
    logic ctrl_wr;
    logic timer_rd;
    logic flag_rd;
    logic other_rd;
    logic other_wr;
  } bus_ev_t;
endpackage

// File: rtl/mbx_bus_decode.sv
module mbx_bus_decode
  import mbx_rdlock_pkg::*;
#(
  parameter int MB_W       = 4,
  parameter int OFS_W      = 3,
  parameter int TIMER_ADDR = 4,
  parameter int FLAG_ADDR  = 8,
  localparam int ADDR_W    = 1 + MB_W + OFS_W
) (
  input  logic              rd,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output bus_ev_t           ev,
  output logic [MB_W-1:0]   idx
);
  localparam logic [ADDR_W-1:0] TMR_A = TIMER_ADDR[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] FLG_A = FLAG_ADDR[ADDR_W-1:0];

  function automatic logic in_mb_space(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1];
  endfunction

  function automatic logic [MB_W-1:0] mb_of(input logic [ADDR_W-1:0] a);
    return a[OFS_W +: MB_W];
  endfunction

  function automatic logic is_ctrl_word(input logic [ADDR_W-1:0] a);
    return in_mb_space(a) && (a[OFS_W-1:0] == '0);
  endfunction

  logic rd_q, wr_q;
  assign rd_q = rd;
  assign wr_q = wr & ~rd;   // reads take priority (R8)

  always_comb begin
    ev          = '0;
    ev.ctrl_rd  = rd_q && is_ctrl_word(addr);
    ev.timer_rd = rd_q && (addr == TMR_A);
    ev.flag_rd  = rd_q && (addr == FLG_A);
    ev.other_rd = rd_q && !is_ctrl_word(addr) && (addr != TMR_A) && (addr != FLG_A);
    ev.ctrl_wr  = wr_q && is_ctrl_word(addr);
    ev.other_wr = wr_q && !is_ctrl_word(addr);
  end

  assign idx = mb_of(addr);

  always_comb begin
    a_r8_one_event: assert ($countones(ev) <= 1);
  end
endmodule

// File: rtl/mbx_lock_fsm.sv
module mbx_lock_fsm
  import mbx_rdlock_pkg::*;
#(
  parameter int MB_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  bus_ev_t         ev,
  input  logic [MB_W-1:0] idx,
  input  logic            busy_hit,
  output logic            lock_valid,
  output logic [MB_W-1:0] lock_idx
);
  logic take_lock, drop_lock, wr_hit;

  assign wr_hit    = ev.ctrl_wr && lock_valid && (idx == lock_idx);
  assign take_lock = ev.ctrl_rd && !busy_hit;
  assign drop_lock = ev.timer_rd || wr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_valid <= 1'b0;
      lock_idx   <= '0;
    end else if (take_lock) begin
      lock_valid <= 1'b1;
      lock_idx   <= idx;
    end else if (drop_lock) begin
      lock_valid <= 1'b0;
    end
  end

  a_r2_lock_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ctrl_rd && !busy_hit) |=> (lock_valid && lock_idx == $past(idx)));

  a_r4_timer_release: assert property (@(posedge clk) disable iff (!rst_n)
    ev.timer_rd |=> !lock_valid);

  a_r5_passive_reads: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.flag_rd || ev.other_rd) |=> ($stable(lock_valid) && $stable(lock_idx)));

  a_r6_busy_keeps_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ctrl_rd && busy_hit) |=> ($stable(lock_valid) && $stable(lock_idx)));

  a_r7_write_release: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ctrl_wr && lock_valid && idx == lock_idx) |=> !lock_valid);

  a_r7_write_other: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.other_wr || (ev.ctrl_wr && (!lock_valid || idx != lock_idx)))
      |=> ($stable(lock_valid) && $stable(lock_idx)));
endmodule

// File: rtl/mbx_busy_report.sv
module mbx_busy_report
  import mbx_rdlock_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int MB_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ev_t           ev,
  input  logic [MB_W-1:0]   idx,
  input  logic [NUM_MB-1:0] rx_busy,
  output logic              busy_hit,
  output logic              host_busy
);
  assign busy_hit = ev.ctrl_rd && rx_busy[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) host_busy <= 1'b0;
    else        host_busy <= busy_hit;
  end

  a_r6_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !ev.ctrl_rd |=> !host_busy);
endmodule

// File: rtl/mbx_rdlock.sv
module mbx_rdlock
  import mbx_rdlock_pkg::*;
#(
  parameter int NUM_MB       = 16,
  parameter int WORDS_PER_MB = 8,
  parameter int TIMER_ADDR   = 4,
  parameter int FLAG_ADDR    = 8,
  localparam int MB_W        = $clog2(NUM_MB),
  localparam int OFS_W       = $clog2(WORDS_PER_MB),
  localparam int ADDR_W      = 1 + MB_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [NUM_MB-1:0] rx_busy,
  output logic              lock_valid,
  output logic [MB_W-1:0]   lock_idx,
  output logic              host_busy
);
  bus_ev_t         ev;
  logic [MB_W-1:0] acc_idx;
  logic            busy_hit;

  mbx_bus_decode #(
    .MB_W(MB_W), .OFS_W(OFS_W), .TIMER_ADDR(TIMER_ADDR), .FLAG_ADDR(FLAG_ADDR)
  ) u_dec (
    .rd(host_rd), .wr(host_wr), .addr(host_addr), .ev(ev), .idx(acc_idx)
  );

  mbx_busy_report #(.NUM_MB(NUM_MB)) u_busy (
    .clk(clk), .rst_n(rst_n), .ev(ev), .idx(acc_idx), .rx_busy(rx_busy),
    .busy_hit(busy_hit), .host_busy(host_busy)
  );

  mbx_lock_fsm #(.MB_W(MB_W)) u_lock (
    .clk(clk), .rst_n(rst_n), .ev(ev), .idx(acc_idx), .busy_hit(busy_hit),
    .lock_valid(lock_valid), .lock_idx(lock_idx)
  );

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!lock_valid && !host_busy));
endmodule

// File: tb/sim_mbx_rdlock.sv
module sim_mbx_rdlock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_rd = 1'b0;
  logic        host_wr = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [15:0] rx_busy = '0;
  logic        lock_valid;
  logic [3:0]  lock_idx;
  logic        host_busy;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic       m_valid = 1'b0;
  logic [3:0] m_idx = '0;
  logic       m_busy = 1'b0;

  always #5 clk = ~clk;

  mbx_rdlock u0 (
    .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_wr(host_wr),
    .host_addr(host_addr), .rx_busy(rx_busy), .lock_valid(lock_valid),
    .lock_idx(lock_idx), .host_busy(host_busy)
  );

  function automatic logic [7:0] mb_addr(input int mb, input int word);
    return {1'b1, mb[3:0], word[2:0]};
  endfunction

  function automatic string tag_of(input logic rd, input logic wr, input logic [7:0] a);
    if (rd && wr) return "R8";
    if (rd && a[7] && a[2:0] == 3'd0) return "R2/R3/R6";
    if (rd && a == 8'h04) return "R4";
    if (rd) return "R5";
    if (wr) return "R7";
    return "R6";
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model(input logic rd, input logic wr, input logic [7:0] a, input logic [15:0] bz);
    logic ctrl;
    ctrl = a[7] && (a[2:0] == 3'd0);
    m_busy = 1'b0;
    if (rd) begin
      if (ctrl) begin
        if (bz[a[6:3]]) m_busy = 1'b1;
        else begin m_valid = 1'b1; m_idx = a[6:3]; end
      end else if (a == 8'h04) m_valid = 1'b0;
    end else if (wr) begin
      if (ctrl && m_valid && m_idx == a[6:3]) m_valid = 1'b0;
    end
  endtask

  task automatic access(input logic rd, input logic wr, input logic [7:0] a, input logic [15:0] bz);
    string t;
    @(negedge clk);
    host_rd = rd; host_wr = wr; host_addr = a; rx_busy = bz;
    model(rd, wr, a, bz);
    t = tag_of(rd, wr, a);
    @(posedge clk);
    #2;
    check(t, "lock_valid", int'(lock_valid), int'(m_valid));
    if (m_valid) check(t, "lock_idx", int'(lock_idx), int'(m_idx));
    check(t, "host_busy", int'(host_busy), int'(m_busy));
    @(negedge clk);
    host_rd = 0; host_wr = 0; rx_busy = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] a;
    logic [15:0] bz;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #2;
    check("R1", "lock_valid", int'(lock_valid), 0);
    check("R1", "host_busy", int'(host_busy), 0);
    @(negedge clk);
    rst_n = 1'b1;

    access(1, 0, mb_addr(3, 0), '0);        // R2 lock mailbox 3
    access(1, 0, mb_addr(3, 1), '0);        // R5 ID word
    access(1, 0, mb_addr(3, 5), '0);        // R5 data word
    access(1, 0, 8'h08, '0);                // R5 flag register
    access(1, 0, 8'h10, '0);                // R5 other register
    access(1, 0, mb_addr(9, 0), '0);        // R3 move lock
    access(1, 0, 8'h04, '0);                // R4 timer read
    access(1, 0, 8'h04, '0);                // R4 timer read with no lock
    access(1, 0, mb_addr(15, 0), '0);       // R2 top index
    access(1, 0, mb_addr(0, 0), 16'h0001);  // R6 busy read keeps lock on 15
    access(1, 0, mb_addr(15, 0), 16'h8000); // R6 busy on locked mailbox
    access(0, 1, mb_addr(6, 0), '0);        // R7 other mailbox ctrl write
    access(0, 1, mb_addr(15, 2), '0);       // R7 payload write
    access(0, 1, 8'h04, '0);                // R7 timer write, no release
    access(0, 1, mb_addr(15, 0), '0);       // R7 release by write
    access(1, 1, mb_addr(5, 0), '0);        // R8 read wins
    access(1, 1, 8'h04, '0);                // R8 read of timer releases

    for (int i = 0; i < 600; i++) begin
      int k;
      logic r, w;
      k = $urandom_range(0, 9);
      case (k)
        0, 1, 2: a = mb_addr($urandom_range(0, 15), 0);
        3, 4:    a = mb_addr($urandom_range(0, 15), $urandom_range(1, 7));
        5:       a = 8'h04;
        6:       a = 8'h08;
        default: a = 8'($urandom_range(0, 255));
      endcase
      bz = '0;
      for (int b = 0; b < 16; b++) if ($urandom_range(0, 7) == 0) bz[b] = 1'b1;
      k = $urandom_range(0, 19);
      r = (k < 13) || (k == 19);
      w = (k >= 13);
      access(r, w, a, bz);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule